// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block turns a wide bank of general-purpose pad inputs into a handful of interrupt lines. It watches 82 GPIO inputs and drives 12 interrupt channels. Software picks one source pin for each channel and one trigger condition for it: high level, low level, rising edge, falling edge, or either edge. Each channel then drives its own interrupt output, and a single global enable bit gates all of them.

The chosen pin passes through a two-flop synchroniser before detection, and the channel output is registered. A level channel stays high for as long as its condition holds. An edge channel gives a pulse one clock wide. The trigger is split over three bit fields. The both-edge bit sits in its own register and wins over the polarity and single-edge bits. A simple word-addressed write port sets up the router, and a combinational read port returns what was written.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every irq_out bit is 0 and all eight register words read back as 0.
- R2: Register map, by byte address. 0x00 is the control word: bit 31 is the global enable, bits 12+n are the edge-mode bits, and bits n are the active-low bits, for channel n from 0 to 11. 0x04 to 0x18 are six selector words. 0x1c is the both-edge word, with bit n for channel n. Reads return the last value written. Bits not listed here read as 0.
- R3: Selector word X, for X from 1 to 6, at byte address 4X, holds two selectors. Bits 7:0 give the pin for channel 2X-2, and bits 23:16 give the pin for channel 2X-1.
- R4: A channel in level mode has its edge bit and both-edge bit at 0. Its output is high while the selected pin is high (active-low bit 0) or low (active-low bit 1). It changes on the third rising clock edge after the pin changes.
- R5: A channel in single-edge mode has its edge bit at 1 and its both-edge bit at 0. It pulses for exactly one cycle on a rising edge of the pin (active-low bit 0) or a falling edge (active-low bit 1), and ignores the opposite edge. The pulse begins on the third rising clock edge after the pin changes.
- R6: A channel with its both-edge bit at 1 pulses for one cycle on every change of the pin, whatever its active-low and edge bits say.
- R7: While the global enable is 0, every irq_out bit is 0 from the next cycle on. Setting the enable while an edge-mode pin sits at a steady level gives no pulse.
- R8: A selector value of 82 or more selects no pin, and that channel's output stays 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 82 | Asynchronous GPIO pad inputs |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 12 | Per-channel interrupt outputs |

## Verification
Some properties are checked by assertions on every cycle:
- A cleared enable silences all outputs on the next cycle.
- An out-of-range selector keeps its channel quiet.
- Reserved register bits read as zero.
- A single-edge output never lasts two cycles while its setup is unchanged.
- An edge-mode pulse always follows a real change in the synchronised sample.

Other behaviour only the bench scenarios can show:
- Each of the six selector words routes to the right pair of channels.
- Every trigger mode reacts to the right pin with the right latency.
- Both-edge overrides the other fields.
- Turning the enable on over a steady pin raises no pulse.

// File: rtl/gir_pkg.sv
package gir_pkg;

  typedef struct packed {
    logic both_en;
    logic edge_en;
    logic low_act;
  } trig_cfg_t;

  // Trigger decision from the current and previous synchronised samples.
  function automatic logic trig_hit(trig_cfg_t c, logic cur, logic prv);
    if (c.both_en) return cur ^ prv;
    if (c.edge_en) return c.low_act ? (prv & ~cur) : (~prv & cur);
    return c.low_act ? ~cur : cur;
  endfunction

endpackage

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
#(
  parameter int unsigned NUM_CH     = 12,
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned AW         = 5,
  parameter int unsigned SEL_HI_LSB = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic                          glb_en,
  output trig_cfg_t [NUM_CH-1:0]        cfg,
  output logic [NUM_CH-1:0][SEL_W-1:0]  sel
);
  localparam int unsigned IW       = AW - 2;
  localparam int unsigned NSEL     = NUM_CH / 2;
  localparam int unsigned BOTH_IDX = NSEL + 1;
  localparam int unsigned EDGE_LSB = NUM_CH;

  logic [IW-1:0]     widx;
  logic [NUM_CH-1:0] low_q, edge_q, both_q;
  logic              en_q;
  logic [31:0]       rd_mask;
  wire               unused_bits = ^{wdata, addr[1:0]};

  assign widx = addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      low_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      sel    <= '0;
    end else if (wr_en) begin
      if (widx == '0) begin
        en_q   <= wdata[31];
        low_q  <= wdata[NUM_CH-1:0];
        edge_q <= wdata[EDGE_LSB +: NUM_CH];
      end
      if (widx == IW'(BOTH_IDX)) both_q <= wdata[NUM_CH-1:0];
      for (int k = 0; k < int'(NSEL); k++) begin
        if (widx == IW'(k + 1)) begin
          sel[2*k]   <= wdata[SEL_W-1:0];
          sel[2*k+1] <= wdata[SEL_HI_LSB +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rdata   = '0;
    rd_mask = '0;
    if (widx == '0) begin
      rdata[31]                  = en_q;
      rdata[EDGE_LSB +: NUM_CH]  = edge_q;
      rdata[NUM_CH-1:0]          = low_q;
      rd_mask[31]                = 1'b1;
      rd_mask[EDGE_LSB +: NUM_CH] = '1;
      rd_mask[NUM_CH-1:0]        = '1;
    end else if (widx == IW'(BOTH_IDX)) begin
      rdata[NUM_CH-1:0]   = both_q;
      rd_mask[NUM_CH-1:0] = '1;
    end else begin
      for (int k = 0; k < int'(NSEL); k++) begin
        if (widx == IW'(k + 1)) begin
          rdata[SEL_W-1:0]              = sel[2*k];
          rdata[SEL_HI_LSB +: SEL_W]    = sel[2*k+1];
          rd_mask[SEL_W-1:0]            = '1;
          rd_mask[SEL_HI_LSB +: SEL_W]  = '1;
        end
      end
    end
  end

  assign glb_en = en_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
    assign cfg[n] = '{both_en: both_q[n], edge_en: edge_q[n], low_act: low_q[n]};
  end

  // R2: bits outside the defined fields never read as one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~rd_mask) == 32'h0);

endmodule

// File: rtl/gir_chan.sv
module gir_chan
  import gir_pkg::*;
#(
  parameter int unsigned NPINS = 82,
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] gpio,
  input  logic [SEL_W-1:0] sel,
  input  trig_cfg_t        cfg,
  input  logic             glb_en,
  output logic             irq
);
  localparam int unsigned SPAN = 1 << SEL_W;

  logic [SPAN-1:0] padded;
  logic            sel_ok, pin_raw;
  logic            s1, s2, s3, irq_q;
  logic            edge_event, single_edge_cfg, any_edge_cfg;

  assign padded  = SPAN'(gpio);
  assign sel_ok  = (32'(sel) < NPINS);
  assign pin_raw = sel_ok ? padded[sel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      s1    <= pin_raw;
      s2    <= s1;
      s3    <= s2;
      irq_q <= glb_en & sel_ok & trig_hit(cfg, s2, s3);
    end
  end

  assign irq             = irq_q;
  assign edge_event      = s2 ^ s3;
  assign single_edge_cfg = cfg.edge_en & ~cfg.both_en;
  assign any_edge_cfg    = cfg.edge_en | cfg.both_en;

  // R8: an unused selector keeps the channel quiet
  p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !irq_q);

  // R5: a single-edge pulse is one cycle wide while the setup holds
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && single_edge_cfg && $stable(cfg)) |=> !irq_q);

  // R5/R6: every edge-mode pulse follows a change of the synchronised sample
  p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past(any_edge_cfg)) |-> $past(edge_event));

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 82,
  parameter int unsigned NUM_CH   = 12,
  parameter int unsigned SEL_W    = 8,
  parameter int unsigned AW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_CH-1:0]   irq_out
);
  logic                         glb_en;
  trig_cfg_t [NUM_CH-1:0]       cfg;
  logic [NUM_CH-1:0][SEL_W-1:0] sel;

  gir_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .glb_en (glb_en),
    .cfg    (cfg),
    .sel    (sel)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    gir_chan #(.NPINS(NUM_PINS), .SEL_W(SEL_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .gpio   (gpio_in),
      .sel    (sel[n]),
      .cfg    (cfg[n]),
      .glb_en (glb_en),
      .irq    (irq_out[n])
    );
  end

  // R7: a cleared global enable silences every channel on the next cycle
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (irq_out == '0));

endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [81:0] gpio = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_router uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // shadow of the programmed setup
  logic [7:0]  sh_sel [12];
  logic        sh_en = 1'b0;
  logic [11:0] sh_low = '0, sh_edg = '0, sh_both = '0;

  typedef struct packed {
    logic [3:0] ch;
    logic [7:0] pin;
    logic low, edg, both, v0, v1, e_pre, e_hit, e_post;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  8'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b1,1'b1}, // level high
    '{4'd1,  8'd81, 1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b0,1'b0}, // level low
    '{4'd5,  8'd40, 1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b0,1'b1,1'b0}, // rising, rises
    '{4'd6,  8'd13, 1'b0,1'b1,1'b0, 1'b1,1'b0, 1'b0,1'b0,1'b0}, // rising, falls
    '{4'd11, 8'd70, 1'b1,1'b1,1'b0, 1'b1,1'b0, 1'b0,1'b1,1'b0}, // falling, falls
    '{4'd4,  8'd22, 1'b1,1'b1,1'b0, 1'b0,1'b1, 1'b0,1'b0,1'b0}, // falling, rises
    '{4'd7,  8'd50, 1'b1,1'b0,1'b1, 1'b0,1'b1, 1'b0,1'b1,1'b0}, // both over level-low
    '{4'd10, 8'd33, 1'b0,1'b1,1'b1, 1'b1,1'b0, 1'b0,1'b1,1'b0}  // both over rising
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_ctrl();
    wr(5'h00, {sh_en, 7'b0, sh_edg, sh_low});
  endtask

  task automatic put_sel(input int x);
    wr(5'(x * 4), {8'b0, sh_sel[2*x-1], 8'b0, sh_sel[2*x-2]});
  endtask

  task automatic put_both();
    wr(5'h1c, {20'b0, sh_both});
  endtask

  task automatic cfg_chan(input int ch, input logic [7:0] pin, input logic low,
                          input logic edg, input logic both);
    sh_sel[ch] = pin; sh_low[ch] = low; sh_edg[ch] = edg; sh_both[ch] = both;
    put_sel(ch / 2 + 1);
    put_ctrl();
    put_both();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cnt;
    bit bad;
    for (int k = 0; k < 12; k++) sh_sel[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(irq_out == 12'h0, "R1 irq", 32'(irq_out), 0);
    for (int w = 0; w < 8; w++) begin
      rd(5'(w * 4), d);
      chk(d == 0, "R1 reg", d, 0);
    end

    // R2: readback and reserved bits
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      wr(5'(w * 4), 32'hFFFF_FFFF);
      rd(5'(w * 4), d);
      e = (w == 0) ? 32'h80FF_FFFF : (w == 7) ? 32'h0000_0FFF : 32'h00FF_00FF;
      chk(d == e, "R2 readback", d, e);
    end

    // return to a clean setup: enabled, all selectors unused
    sh_en = 1'b1; sh_low = '0; sh_edg = '0; sh_both = '0;
    put_ctrl(); put_both();
    for (int x = 1; x <= 6; x++) put_sel(x);
    rd(5'h08, d);
    chk(d == 32'h00FF_00FF, "R2 sel word", d, 32'h00FF_00FF);

    // R4/R5/R6: vector table
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      string req;
      v = VECS[i];
      req = v.both ? "R6" : (v.edg ? "R5" : "R4");
      gpio[v.pin] = v.v0;
      cfg_chan(int'(v.ch), v.pin, v.low, v.edg, v.both);
      repeat (5) @(negedge clk);
      chk(irq_out[v.ch] == v.e_pre, {req, " before"}, 32'(irq_out[v.ch]), 32'(v.e_pre));
      gpio[v.pin] = v.v1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(irq_out[v.ch] == v.e_pre, {req, " latency"}, 32'(irq_out[v.ch]), 32'(v.e_pre));
      @(negedge clk);
      chk(irq_out[v.ch] == v.e_hit, {req, " hit"}, 32'(irq_out[v.ch]), 32'(v.e_hit));
      @(negedge clk);
      chk(irq_out[v.ch] == v.e_post, {req, " after"}, 32'(irq_out[v.ch]), 32'(v.e_post));
      sh_sel[v.ch] = 8'hFF; sh_low[v.ch] = 0; sh_edg[v.ch] = 0; sh_both[v.ch] = 0;
      put_sel(int'(v.ch) / 2 + 1);
      gpio = '0;
    end
    put_ctrl(); put_both();

    // R3: selector word 2 serves channels 2 (low field) and 3 (high field)
    cfg_chan(2, 8'd10, 0, 0, 0);
    cfg_chan(3, 8'd20, 0, 0, 0);
    gpio[20] = 1'b1;
    repeat (5) @(negedge clk);
    chk(irq_out[3:2] == 2'b10, "R3 high field", 32'(irq_out[3:2]), 2);
    gpio[20] = 1'b0; gpio[10] = 1'b1;
    repeat (5) @(negedge clk);
    chk(irq_out[3:2] == 2'b01, "R3 low field", 32'(irq_out[3:2]), 1);
    gpio = '0;
    sh_sel[2] = 8'hFF; sh_sel[3] = 8'hFF; put_sel(2);

    // R8: selector 82 is unused, 81 is the last pin
    cfg_chan(9, 8'd82, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk(irq_out[9] == 1'b0, "R8 sel 82", 32'(irq_out[9]), 0);
    cfg_chan(9, 8'd81, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk(irq_out[9] == 1'b1, "R8 sel 81", 32'(irq_out[9]), 1);
    cfg_chan(9, 8'd255, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk(irq_out[9] == 1'b0, "R8 sel 255", 32'(irq_out[9]), 0);
    sh_low[9] = 0; put_ctrl();

    // R7: global enable
    gpio[5] = 1'b1;
    cfg_chan(0, 8'd5, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk(irq_out[0] == 1'b1, "R7 enabled level", 32'(irq_out[0]), 1);
    sh_en = 1'b0; put_ctrl();
    @(negedge clk);
    chk(irq_out == 12'h0, "R7 disabled", 32'(irq_out), 0);
    gpio[5] = 1'b0;
    sh_edg[0] = 1'b1; put_ctrl();
    gpio[5] = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq_out == 12'h0, "R7 edge while disabled", 32'(irq_out), 0);
    sh_en = 1'b1; put_ctrl();
    bad = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (irq_out[0]) bad = 1;
    end
    chk(!bad, "R7 no spurious edge on enable", 32'(bad), 0);
    gpio[5] = 1'b0;
    repeat (4) @(negedge clk);
    gpio[5] = 1'b1;
    cnt = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (irq_out[0]) cnt++;
    end
    chk(cnt == 1, "R7 real edge after enable", 32'(cnt), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule